// File: doc/BRIEF.md
# CAN Receive Buffer Matcher

This block chooses which receive message buffer takes a newly arrived CAN frame. When a frame identifier arrives with its valid strobe, every participating buffer is checked. A buffer takes part if its index is within the configured buffer count and its status code is a receive code. Its stored identifier must also equal the incoming one on every bit its mask selects. From the candidates that pass, the block picks one index and emits a one-cycle write strobe with the new status code. The surrounding controller then stores the payload and updates that buffer.

Two selection policies exist, picked by a mode input. In the default shared-mask policy, all buffers use one common mask, except two dedicated buffers that each use their own shared mask. The lowest matching buffer always wins: it becomes full if it was empty, and is overwritten and marked overrun if it was still occupied. In the enhanced policy, each buffer uses its own mask and occupied matches are skipped, so consecutive matching buffers act as a queue. When the whole queue is occupied, the highest matching buffer is overwritten and marked overrun.

The count of participating buffers is held in an internal register that only accepts writes while the freeze input is high.

Top module: `can_rx_matcher`

## Requirements
- R1: After reset the buffer-count register holds NUM_MB-1, so all NUM_MB buffers take part, and wr_en is low.
- R2: Only buffers with index less than or equal to the buffer-count register take part in matching.
- R3: A write to the buffer-count register (cfg_wr high) takes effect only when freeze is high in the same cycle; otherwise it is ignored.
- R4: A mask bit of 1 requires the identifier bit to equal the buffer's identifier bit; a mask bit of 0 makes that bit don't-care.
- R5: With enh_mode low, buffer DED_A_IDX (default 14) uses mask_a, buffer DED_B_IDX (default 15) uses mask_b, and every other buffer uses glb_mask; per-buffer masks have no effect.
- R6: With enh_mode low, if the lowest-index matching buffer holds code 4'b0010 (full) or 4'b0110 (overrun), that buffer is selected and the new code is 4'b0110, even if a higher matching buffer is empty.
- R7: With enh_mode low, if the lowest-index matching buffer holds code 4'b0100 (empty), it is selected with new code 4'b0010.
- R8: With enh_mode high, each buffer compares under its own mask from mb_mask_flat (bits [i*ID_W +: ID_W]); the shared masks have no effect.
- R9: With enh_mode high, the lowest-index matching buffer with code 4'b0100 is selected with new code 4'b0010; occupied matches are skipped.
- R10: With enh_mode high and every matching buffer occupied, the highest-index matching buffer is selected with new code 4'b0110.
- R11: Only buffers whose code is 4'b0100, 4'b0010 or 4'b0110 take part; a buffer with any other code is never selected, and wr_code is always 4'b0010 or 4'b0110.
- R12: wr_en pulses for exactly the cycle after a rx_valid cycle that found a match; when nothing matches, or rx_valid is low, wr_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Controller frozen; enables buffer-count writes |
| cfg_wr | input | 1 | Write strobe for the buffer-count register |
| cfg_maxmb | input | IDX_W | Highest participating buffer index to write |
| enh_mode | input | 1 | 0: shared masks with overwrite; 1: per-buffer masks with queue |
| rx_valid | input | 1 | A received identifier is presented this cycle |
| rx_id | input | ID_W | Received frame identifier |
| glb_mask | input | ID_W | Shared mask for ordinary buffers |
| mask_a | input | ID_W | Shared mask for buffer DED_A_IDX |
| mask_b | input | ID_W | Shared mask for buffer DED_B_IDX |
| mb_mask_flat | input | NUM_MB*ID_W | Per-buffer masks, buffer i at [i*ID_W +: ID_W] |
| mb_id_flat | input | NUM_MB*ID_W | Per-buffer identifiers, buffer i at [i*ID_W +: ID_W] |
| mb_code_flat | input | NUM_MB*4 | Per-buffer status codes, buffer i at [i*4 +: 4] |
| wr_en | output | 1 | Selected buffer is to be written |
| wr_idx | output | IDX_W | Index of the selected buffer |
| wr_code | output | 4 | New status code for the selected buffer |

## Verification
Almost all state sits in the buffer-count register. A wrong value there shows only when a frame matches a buffer near the count boundary, so the bench sends frames that hit the boundary buffer right after each accepted and each refused write. Selection faults show on the very next cycle after rx_valid, as a wrong wr_idx or wr_code or as a missing or extra strobe. The bench therefore builds buffer sets where the lowest match, the lowest free match and the highest match are all different buffers, and a swapped priority changes the answer.

// File: rtl/can_rxm_pkg.sv
package can_rxm_pkg;
    typedef logic [3:0] mb_code_t;

    localparam mb_code_t CODE_EMPTY = 4'b0100;
    localparam mb_code_t CODE_FULL  = 4'b0010;
    localparam mb_code_t CODE_OVR   = 4'b0110;

    function automatic logic code_is_rx(input mb_code_t c);
        return (c == CODE_EMPTY) || (c == CODE_FULL) || (c == CODE_OVR);
    endfunction
endpackage

// File: rtl/mb_match_array.sv
module mb_match_array
    import can_rxm_pkg::*;
#(
    parameter int NUM_MB    = 16,
    parameter int ID_W      = 29,
    parameter int DED_A_IDX = 14,
    parameter int DED_B_IDX = 15,
    localparam int IDX_W    = $clog2(NUM_MB)
) (
    input  logic [ID_W-1:0]        rx_id,
    input  logic                   enh_mode,
    input  logic [IDX_W-1:0]       maxmb,
    input  logic [ID_W-1:0]        glb_mask,
    input  logic [ID_W-1:0]        mask_a,
    input  logic [ID_W-1:0]        mask_b,
    input  logic [NUM_MB*ID_W-1:0] mb_mask_flat,
    input  logic [NUM_MB*ID_W-1:0] mb_id_flat,
    input  logic [NUM_MB*4-1:0]    mb_code_flat,
    output logic [NUM_MB-1:0]      hit,
    output logic [NUM_MB-1:0]      vacant
);
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic [ID_W-1:0] shared_mask;
        logic [ID_W-1:0] eff_mask;
        mb_code_t        code;
        logic            in_range;

        if (g == DED_A_IDX) begin : g_ded_a
            assign shared_mask = mask_a;
        end else if (g == DED_B_IDX) begin : g_ded_b
            assign shared_mask = mask_b;
        end else begin : g_glb
            assign shared_mask = glb_mask;
        end

        assign eff_mask = enh_mode ? mb_mask_flat[g*ID_W +: ID_W] : shared_mask;
        assign code     = mb_code_flat[g*4 +: 4];
        assign in_range = (IDX_W+1)'(g) <= {1'b0, maxmb};
        assign hit[g]   = in_range && code_is_rx(code) &&
                          (((rx_id ^ mb_id_flat[g*ID_W +: ID_W]) & eff_mask) == '0);
        assign vacant[g] = hit[g] && (code == CODE_EMPTY);
    end
endmodule

// File: rtl/mb_pick.sv
module mb_pick #(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [NUM_MB-1:0] hit,
    input  logic [NUM_MB-1:0] vacant,
    output logic              any_hit,
    output logic              any_vacant,
    output logic [IDX_W-1:0]  first_hit,
    output logic [IDX_W-1:0]  first_vacant,
    output logic [IDX_W-1:0]  last_hit
);
    always_comb begin
        first_hit    = '0;
        first_vacant = '0;
        for (int i = NUM_MB-1; i >= 0; i--) begin
            if (hit[i])    first_hit    = IDX_W'(i);
            if (vacant[i]) first_vacant = IDX_W'(i);
        end
    end

    always_comb begin
        last_hit = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (hit[i]) last_hit = IDX_W'(i);
        end
    end

    assign any_hit    = |hit;
    assign any_vacant = |vacant;
endmodule

// File: rtl/can_rx_matcher.sv
module can_rx_matcher
    import can_rxm_pkg::*;
#(
    parameter int NUM_MB    = 16,
    parameter int ID_W      = 29,
    parameter int DED_A_IDX = 14,
    parameter int DED_B_IDX = 15,
    localparam int IDX_W    = $clog2(NUM_MB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   freeze,
    input  logic                   cfg_wr,
    input  logic [IDX_W-1:0]       cfg_maxmb,
    input  logic                   enh_mode,
    input  logic                   rx_valid,
    input  logic [ID_W-1:0]        rx_id,
    input  logic [ID_W-1:0]        glb_mask,
    input  logic [ID_W-1:0]        mask_a,
    input  logic [ID_W-1:0]        mask_b,
    input  logic [NUM_MB*ID_W-1:0] mb_mask_flat,
    input  logic [NUM_MB*ID_W-1:0] mb_id_flat,
    input  logic [NUM_MB*4-1:0]    mb_code_flat,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [3:0]             wr_code
);
    typedef struct packed {
        logic [IDX_W-1:0] maxmb;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        mb_code_t         wr_code;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_MB-1:0] hit, vacant;
    logic              any_hit, any_vacant;
    logic [IDX_W-1:0]  first_hit, first_vacant, last_hit;
    logic [IDX_W-1:0]  maxmb_q;

    assign maxmb_q = st_q.maxmb;

    mb_match_array #(
        .NUM_MB(NUM_MB), .ID_W(ID_W), .DED_A_IDX(DED_A_IDX), .DED_B_IDX(DED_B_IDX)
    ) u_match (
        .rx_id(rx_id), .enh_mode(enh_mode), .maxmb(st_q.maxmb),
        .glb_mask(glb_mask), .mask_a(mask_a), .mask_b(mask_b),
        .mb_mask_flat(mb_mask_flat), .mb_id_flat(mb_id_flat),
        .mb_code_flat(mb_code_flat), .hit(hit), .vacant(vacant)
    );

    mb_pick #(.NUM_MB(NUM_MB)) u_pick (
        .hit(hit), .vacant(vacant), .any_hit(any_hit), .any_vacant(any_vacant),
        .first_hit(first_hit), .first_vacant(first_vacant), .last_hit(last_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (cfg_wr && freeze) begin
            st_d.maxmb = cfg_maxmb;
        end
        if (rx_valid && any_hit) begin
            st_d.wr_en = 1'b1;
            if (!enh_mode) begin
                st_d.wr_idx  = first_hit;
                st_d.wr_code = vacant[first_hit] ? CODE_FULL : CODE_OVR;
            end else if (any_vacant) begin
                st_d.wr_idx  = first_vacant;
                st_d.wr_code = CODE_FULL;
            end else begin
                st_d.wr_idx  = last_hit;
                st_d.wr_code = CODE_OVR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.maxmb   <= IDX_W'(NUM_MB-1);
            st_q.wr_en   <= 1'b0;
            st_q.wr_idx  <= '0;
            st_q.wr_code <= CODE_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.wr_en;
    assign wr_idx  = st_q.wr_idx;
    assign wr_code = st_q.wr_code;
endmodule

// File: rtl/can_rxm_checker.sv
module can_rxm_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze,
    input logic             rx_valid,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [3:0]       wr_code,
    input logic [IDX_W-1:0] maxmb
);
    a_r12_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rx_valid));

    a_r11_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_code == 4'b0010 || wr_code == 4'b0110));

    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx <= $past(maxmb)));

    a_r3_count_frozen_only: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> $stable(maxmb));
endmodule

bind can_rx_matcher can_rxm_checker #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .rx_valid(rx_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code), .maxmb(maxmb_q)
);

// File: tb/sim_can_rx_matcher.sv
`timescale 1ns/1ps
module sim_can_rx_matcher;
    localparam int NMB   = 16;
    localparam int IW    = 29;
    localparam int XW    = 4;
    localparam logic [3:0] C_EMP = 4'b0100, C_FUL = 4'b0010, C_OVR = 4'b0110;

    logic clk = 0, rst_n = 0, freeze = 0, cfg_wr = 0, enh_mode = 0, rx_valid = 0;
    logic [XW-1:0] cfg_maxmb = '0;
    logic [IW-1:0] rx_id = '0, glb_mask = '1, mask_a = '1, mask_b = '1;
    logic [IW-1:0] id_a [NMB];
    logic [IW-1:0] msk_a [NMB];
    logic [3:0]    code_a [NMB];
    logic [NMB*IW-1:0] mb_mask_flat, mb_id_flat;
    logic [NMB*4-1:0]  mb_code_flat;
    logic wr_en;
    logic [XW-1:0] wr_idx;
    logic [3:0] wr_code;

    int checks = 0, fails = 0;
    int shadow_max = NMB-1;
    logic [8:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NMB; i++) begin
            mb_id_flat[i*IW +: IW]   = id_a[i];
            mb_mask_flat[i*IW +: IW] = msk_a[i];
            mb_code_flat[i*4 +: 4]   = code_a[i];
        end
    end

    can_rx_matcher u0 (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_wr(cfg_wr), .cfg_maxmb(cfg_maxmb),
        .enh_mode(enh_mode), .rx_valid(rx_valid), .rx_id(rx_id), .glb_mask(glb_mask),
        .mask_a(mask_a), .mask_b(mask_b), .mb_mask_flat(mb_mask_flat),
        .mb_id_flat(mb_id_flat), .mb_code_flat(mb_code_flat),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code)
    );

    function automatic logic [8:0] model(input logic [IW-1:0] rid, input logic enh);
        int first = -1, last = -1, free = -1;
        logic [IW-1:0] m;
        for (int i = 0; i < NMB; i++) begin
            if (i > shadow_max) continue;
            if (!(code_a[i] == C_EMP || code_a[i] == C_FUL || code_a[i] == C_OVR)) continue;
            if (enh) m = msk_a[i];
            else if (i == 14) m = mask_a;
            else if (i == 15) m = mask_b;
            else m = glb_mask;
            if (((rid ^ id_a[i]) & m) != '0) continue;
            if (first < 0) first = i;
            last = i;
            if (code_a[i] == C_EMP && free < 0) free = i;
        end
        if (first < 0) return 9'd0;
        if (!enh) return {1'b1, XW'(first), (code_a[first] == C_EMP) ? C_FUL : C_OVR};
        if (free >= 0) return {1'b1, XW'(free), C_FUL};
        return {1'b1, XW'(last), C_OVR};
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual en=%0b idx=%0d code=%b expected en=%0b idx=%0d code=%b",
                     tag, act[8], act[7:4], act[3:0], exp[8], exp[7:4], exp[3:0]);
        end
    endtask

    // monitor: pops one expected item for every frame the driver sent
    always @(posedge clk) begin
        logic v;
        v = rx_valid;
        #5;
        if (v && exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e[8]) check(t, {wr_en, wr_idx, wr_code}, e);
            else      check(t, {wr_en, 8'd0}, 9'd0);
        end else if (!v && rst_n && wr_en) begin
            check("R12 strobe without frame", {wr_en, 8'd0}, 9'd0);
        end
    end

    task automatic send(input string tag, input logic [IW-1:0] rid, input logic enh);
        @(negedge clk);
        rx_id = rid; enh_mode = enh; rx_valid = 1'b1;
        exp_q.push_back(model(rid, enh));
        tag_q.push_back(tag);
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_max(input logic [XW-1:0] v, input logic frz);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_maxmb = v; freeze = frz;
        @(negedge clk);
        cfg_wr = 1'b0; freeze = 1'b0;
        if (frz) shadow_max = v;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NMB; i++) begin
            id_a[i] = '0; msk_a[i] = '1; code_a[i] = 4'b0000;
        end
        glb_mask = '1; mask_a = '1; mask_b = '1;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        check("R1 reset strobe", {wr_en, 8'd0}, 9'd0);
        rst_n = 1'b1;

        // R1: full count after reset, buffer 15 reachable
        id_a[15] = 29'h155; code_a[15] = C_EMP;
        send("R1 default count", 29'h155, 1'b0);

        // R4: don't-care bits
        clear_all();
        glb_mask = 29'h0F0; id_a[2] = 29'h0A3; code_a[2] = C_EMP;
        send("R4 masked match", 29'h1AC, 1'b0);
        send("R4 care bit mismatch", 29'h0B3, 1'b0);

        // R7 / R6 legacy
        clear_all();
        id_a[1] = 29'h42; code_a[1] = C_EMP; id_a[5] = 29'h42; code_a[5] = C_EMP;
        send("R7 first empty", 29'h42, 1'b0);
        code_a[1] = C_FUL;
        send("R6 overwrite full", 29'h42, 1'b0);
        code_a[1] = C_OVR;
        send("R6 overwrite overrun", 29'h42, 1'b0);

        // R5 dedicated masks, per-buffer masks ignored
        clear_all();
        mask_a = '0; id_a[14] = 29'h7; code_a[14] = C_EMP;
        id_a[3] = 29'h9; msk_a[3] = '0; code_a[3] = C_EMP;
        send("R5 mask_a used", 29'h1234, 1'b0);
        clear_all();
        mask_b = 29'h00F; id_a[15] = 29'h5; code_a[15] = C_EMP;
        id_a[14] = 29'h5; code_a[14] = C_EMP; mask_a = 29'hF00;
        id_a[14] = 29'h305;
        send("R5 mask_b used", 29'h3F5, 1'b0);

        // R8 per-buffer masks in enhanced mode
        clear_all();
        glb_mask = '0; id_a[4] = 29'hAA; code_a[4] = C_EMP;
        id_a[6] = 29'hA0; msk_a[6] = 29'h0F0; code_a[6] = C_EMP;
        send("R8 own mask", 29'hA5, 1'b1);

        // R9 / R10 queue
        clear_all();
        for (int i = 2; i <= 9; i += 3) begin id_a[i] = 29'h33; code_a[i] = C_FUL; end
        code_a[8] = C_EMP;
        send("R9 skip occupied", 29'h33, 1'b1);
        code_a[8] = C_OVR;
        send("R10 all occupied last", 29'h33, 1'b1);

        // R11 non-receive codes ignored
        clear_all();
        id_a[0] = 29'h11; code_a[0] = 4'b1000; id_a[7] = 29'h11; code_a[7] = 4'b0000;
        id_a[9] = 29'h11; code_a[9] = C_FUL;
        send("R11 skip tx codes", 29'h11, 1'b0);
        code_a[9] = 4'b1100;
        send("R11 R12 no match no strobe", 29'h11, 1'b1);

        // R3 / R2 buffer count
        clear_all();
        id_a[10] = 29'h77; code_a[10] = C_EMP;
        write_max(4'd3, 1'b0);
        send("R3 write ignored without freeze", 29'h77, 1'b0);
        write_max(4'd3, 1'b1);
        send("R2 buffer beyond count", 29'h77, 1'b0);
        id_a[3] = 29'h77; code_a[3] = C_EMP;
        send("R2 boundary buffer", 29'h77, 1'b0);
        write_max(4'd15, 1'b1);
        send("R3 write under freeze", 29'h77, 1'b1);

        // mixed patterns
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NMB; i++) begin
                int c;
                id_a[i] = IW'($urandom_range(0, 3));
                msk_a[i] = IW'($urandom_range(0, 3));
                c = $urandom_range(0, 4);
                code_a[i] = (c == 0) ? C_EMP : (c == 1) ? C_FUL : (c == 2) ? C_OVR :
                            (c == 3) ? 4'b1000 : C_EMP;
            end
            glb_mask = IW'($urandom_range(0, 3));
            mask_a = IW'($urandom_range(0, 3));
            mask_b = IW'($urandom_range(0, 3));
            if (n % 50 == 25) write_max(XW'($urandom_range(0, 15)), 1'b1);
            send("R9 R10 R6 R7 mixed", IW'($urandom_range(0, 3)), logic'($urandom_range(0, 1)));
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule